// File: doc/BRIEF.md
# Preset-Driven Serial Link Receiver

This block takes serial bits that arrive as a gated copy of the communication clock, called the data clock here, and turns them back into words. The data clock never reaches an ordinary data or logic input. It drives only the asynchronous preset of one capture flip-flop. That flip-flop has its data input tied to 0, is always enabled, and is clocked by the same communication clock that the sender gated. In a cycle where the sender lets a clock pulse through, the preset drives the flip-flop output high. In a cycle with no pulse, the next communication-clock edge loads the 0. The flip-flop output is therefore a level copy of the transmitted bit.

A counter-steered shift register samples the recovered level once per communication-clock cycle. It shifts each bit in most-significant first and completes a word every `WORD_W` bits. Words are framed back to back, starting from reset. A frame-start input lets the sender realign the framing at any bit and throw away a partial word. Each completed word is handed to the task clock through a toggle flag and a synchronizer. The task side then presents the word together with a one-cycle valid strobe.

`rst` is synchronous, active high, and is sampled by both clocks.

Top module: `pulse_link_receiver`

## Requirements
- R1: `rx_bit` is 1 during the low phase of a communication-clock cycle whose data clock pulsed, and 0 during the low phase of a cycle without a pulse.
- R2: A pulse is read as bit value 1 and a missing pulse as 0, and bits are assembled most-significant first. Pulses for 1,0,0,1,1,0,1,0 yield `word` = 8'h9A.
- R3: `word_valid` is high for exactly one task-clock cycle per completed word, and never on two consecutive cycles.
- R4: With the task clock equal to the communication clock and two synchronizer stages, `word` and `word_valid` update on the fourth rising edge after the edge that opens the last bit's pulse cycle.
- R5: After reset, framing starts with no frame-start input. The first word's MSB is the pulse cycle opened by the last rising edge at which `rst` is high.
- R6: The bit counter wraps after `WORD_W` bits, so words sent back to back complete every 8 cycles and their strobes come 8 cycles apart.
- R7: `frame_start` high at the rising edge that opens a pulse cycle makes that bit the MSB of a new word. Any partial word is dropped and produces no strobe.
- R8: While `rst` is high, `word` is cleared to 0, `word_valid` is 0, and the bit counter returns to zero. A word cut off by reset is never presented.
- R9: `word` holds its value in every cycle in which `word_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| com_clk | input | 1 | Communication clock, the same clock the sender gates |
| task_clk | input | 1 | Clock of the receiving task |
| rst | input | 1 | Synchronous active-high reset, seen by both clocks |
| data_clk | input | 1 | Gated data clock; drives only the capture preset |
| frame_start | input | 1 | Realigns the bit counter; sampled at the edge that opens the MSB pulse |
| rx_bit | output | 1 | Recovered bit level |
| word | output | WORD_W | Last completed word (task clock) |
| word_valid | output | 1 | One-cycle strobe for a new `word` (task clock) |

## Verification
`rx_bit` is due within the pulse cycle itself, so the bench checks it on the falling edge that ends that cycle. `word` and `word_valid` are due four rising edges after the edge that opens the last bit's pulse cycle. When the driver sets up the last bit, it stamps each expected word with that due cycle count. The monitor samples on falling edges, pops the queue on each strobe, and compares both the value and the cycle stamp. The sequences cover reset-aligned start, back-to-back words, realignment in mid-word and at a word boundary, and a reset in mid-word; after each, the queue must be empty.

// File: rtl/plrx_pkg.sv
package plrx_pkg;

    localparam int unsigned DEF_WORD_W      = 8;
    localparam int unsigned DEF_SYNC_STAGES = 2;

    // Action taken by the deserializer on one communication-clock edge.
    typedef enum logic [1:0] {
        STEP_CLEAR,
        STEP_SHIFT,
        STEP_REALIGN,
        STEP_FINISH
    } step_e;

    function automatic step_e pick_step(input logic clear, input logic realign,
                                        input logic last_bit);
        if (clear)    return STEP_CLEAR;
        if (realign)  return STEP_REALIGN;
        if (last_bit) return STEP_FINISH;
        return STEP_SHIFT;
    endfunction

endpackage

// File: rtl/plrx_preset_capture.sv
// Recovery flop: data input tied low, always enabled, pulse train on the
// asynchronous preset only.
module plrx_preset_capture (
    input  logic com_clk,
    input  logic pulse_in,
    output logic level_out
);

    always_ff @(posedge com_clk or posedge pulse_in) begin
        if (pulse_in) level_out <= 1'b1;
        else          level_out <= 1'b0;
    end

endmodule

// File: rtl/plrx_deserializer.sv
module plrx_deserializer
    import plrx_pkg::*;
#(
    parameter int unsigned WORD_W = DEF_WORD_W
) (
    input  logic              com_clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              bit_in,
    output logic [WORD_W-1:0] word_out,
    output logic              word_tgl
);

    localparam int unsigned     CNT_W    = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] ONE_IDX  = CNT_W'(1);

    logic              realign_q;
    logic [CNT_W-1:0]  bit_idx;
    logic [WORD_W-1:0] shreg;
    logic [WORD_W-1:0] next_shift;
    step_e             step;

    // frame_start arrives with the pulse; the level is sampled one edge later.
    always_comb begin
        next_shift = {shreg[WORD_W-2:0], bit_in};
        step       = pick_step(rst, realign_q, bit_idx == LAST_IDX);
    end

    always_ff @(posedge com_clk) begin
        realign_q <= rst ? 1'b0 : frame_start;
        case (step)
            STEP_CLEAR: begin
                bit_idx  <= '0;
                shreg    <= '0;
                word_out <= '0;
                word_tgl <= 1'b0;
            end
            STEP_REALIGN: begin
                bit_idx <= ONE_IDX;
                shreg   <= WORD_W'(bit_in);
            end
            STEP_FINISH: begin
                bit_idx  <= '0;
                shreg    <= '0;
                word_out <= next_shift;
                word_tgl <= ~word_tgl;
            end
            default: begin
                bit_idx <= bit_idx + ONE_IDX;
                shreg   <= next_shift;
            end
        endcase
    end

endmodule

// File: rtl/plrx_word_handoff.sv
module plrx_word_handoff
    import plrx_pkg::*;
#(
    parameter int unsigned WORD_W      = DEF_WORD_W,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic              task_clk,
    input  logic              rst,
    input  logic              tgl_in,
    input  logic [WORD_W-1:0] word_in,
    output logic              word_valid,
    output logic [WORD_W-1:0] word_out
);

    logic [SYNC_STAGES:0] sync_q;
    logic                 seen_flip;

    // word_in is held for a whole word period, so it is stable once the flag lands.
    always_comb seen_flip = sync_q[SYNC_STAGES] ^ sync_q[SYNC_STAGES-1];

    always_ff @(posedge task_clk) begin
        if (rst) begin
            sync_q     <= '0;
            word_valid <= 1'b0;
            word_out   <= '0;
        end else begin
            sync_q     <= {sync_q[SYNC_STAGES-1:0], tgl_in};
            word_valid <= seen_flip;
            if (seen_flip) word_out <= word_in;
        end
    end

endmodule

// File: rtl/pulse_link_receiver.sv
module pulse_link_receiver
    import plrx_pkg::*;
#(
    parameter int unsigned WORD_W      = DEF_WORD_W,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic              com_clk,
    input  logic              task_clk,
    input  logic              rst,
    input  logic              data_clk,
    input  logic              frame_start,
    output logic              rx_bit,
    output logic [WORD_W-1:0] word,
    output logic              word_valid
);

    logic              rx_level;
    logic [WORD_W-1:0] word_com;
    logic              word_tgl;

    plrx_preset_capture u_capture (
        .com_clk   (com_clk),
        .pulse_in  (data_clk),
        .level_out (rx_level)
    );

    plrx_deserializer #(.WORD_W(WORD_W)) u_deser (
        .com_clk     (com_clk),
        .rst         (rst),
        .frame_start (frame_start),
        .bit_in      (rx_level),
        .word_out    (word_com),
        .word_tgl    (word_tgl)
    );

    plrx_word_handoff #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_handoff (
        .task_clk   (task_clk),
        .rst        (rst),
        .tgl_in     (word_tgl),
        .word_in    (word_com),
        .word_valid (word_valid),
        .word_out   (word)
    );

    assign rx_bit = rx_level;

endmodule

// File: rtl/plrx_checker.sv
module plrx_checker #(
    parameter int unsigned WORD_W = 8
) (
    input logic              com_clk,
    input logic              task_clk,
    input logic              rst,
    input logic              frame_start,
    input logic              word_tgl,
    input logic              word_valid,
    input logic [WORD_W-1:0] word
);

    localparam int unsigned GAP_W = $clog2(WORD_W) + 1;

    logic             ticked = 1'b0;
    logic             start_q;
    logic             tgl_q;
    logic [GAP_W-1:0] gap;

    // Bits consumed since the last observed word completion or realignment.
    always_ff @(posedge com_clk) begin
        if (rst) begin
            start_q <= 1'b0;
            tgl_q   <= 1'b0;
            gap     <= '0;
        end else begin
            start_q <= frame_start;
            tgl_q   <= word_tgl;
            if (start_q || (word_tgl != tgl_q)) gap <= GAP_W'(1);
            else                                gap <= gap + GAP_W'(1);
        end
    end

    always_ff @(posedge task_clk) ticked <= 1'b1;

    a_r6_wrap_period: assert property (@(posedge com_clk) disable iff (rst)
        (word_tgl != tgl_q) |-> (gap == GAP_W'(WORD_W)));

    a_r3_valid_single: assert property (@(posedge task_clk) disable iff (rst)
        word_valid |=> !word_valid);

    a_r9_word_hold: assert property (@(posedge task_clk) disable iff (rst)
        !word_valid |-> $stable(word));

    a_r8_reset_clear: assert property (@(posedge task_clk)
        (ticked && $past(rst)) |-> (word == '0 && !word_valid));

endmodule

bind pulse_link_receiver plrx_checker #(.WORD_W(WORD_W)) u_plrx_checker (
    .com_clk     (com_clk),
    .task_clk    (task_clk),
    .rst         (rst),
    .frame_start (frame_start),
    .word_tgl    (word_tgl),
    .word_valid  (word_valid),
    .word        (word)
);

// File: tb/pulse_link_receiver_test.sv
module pulse_link_receiver_test;

    typedef struct {
        logic [7:0] value;
        int         due;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ce = 1'b0;
    logic       sof = 1'b0;
    logic       data_clk;
    logic       rx_bit;
    logic [7:0] word;
    logic       word_valid;

    int         cyc = 0;
    int         compared = 0;
    int         mismatched = 0;
    bit         mon_en = 1'b0;
    bit         done = 1'b0;
    string      cur_req = "R2";
    exp_t       expq[$];
    logic [7:0] last_word = '0;
    logic       prev_valid = 1'b0;

    always #2 clk = ~clk;
    assign data_clk = clk & ce;   // glitch-free gating: ce changes while clk is low

    always @(posedge clk) cyc <= cyc + 1;

    pulse_link_receiver uut (
        .com_clk     (clk),
        .task_clk    (clk),
        .rst         (rst),
        .data_clk    (data_clk),
        .frame_start (sof),
        .rx_bit      (rx_bit),
        .word        (word),
        .word_valid  (word_valid)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Entered on a falling edge; leaves on the falling edge ending the pulse cycle.
    task automatic drive_bit(input logic b, input logic s);
        ce  = b;
        sof = s;
        @(posedge clk);
        @(negedge clk);
        sof = 1'b0;
        chk(rx_bit === b, "R1 recovered level", rx_bit, b);
    endtask

    task automatic send_word(input logic [7:0] w, input logic with_start);
        for (int i = 7; i >= 0; i--) begin
            if (i == 0) expq.push_back('{w, cyc + 5});
            drive_bit(w[i], (i == 7) && with_start);
        end
    endtask

    // R5: MSB pulse opened by the last reset-high edge, reset released after it.
    task automatic send_word_from_reset(input logic [7:0] w);
        ce = w[7];
        @(posedge clk);
        @(negedge clk);
        chk(rx_bit === w[7], "R1 recovered level", rx_bit, w[7]);
        rst = 1'b0;
        for (int i = 6; i >= 0; i--) begin
            if (i == 0) expq.push_back('{w, cyc + 5});
            drive_bit(w[i], 1'b0);
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (mon_en && !rst) begin
            if (word_valid) begin
                chk(!prev_valid, "R3 strobe longer than one cycle", prev_valid, 0);
                if (expq.size() == 0) begin
                    chk(1'b0, {cur_req, " R3 unexpected strobe"}, word, 0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    chk(word === e.value, {cur_req, " R2 word value"}, word, e.value);
                    chk(cyc == e.due, {cur_req, " R4 R6 strobe cycle"}, cyc, e.due);
                end
            end else begin
                chk(word === last_word, "R9 word held", word, last_word);
            end
        end
        last_word  = word;
        prev_valid = word_valid;
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            chk(1'b0, "watchdog expired", cyc, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        chk(word === 8'h00 && word_valid === 1'b0, "R8 reset state", {word_valid, word}, 0);
        mon_en = 1'b1;

        cur_req = "R5";
        send_word_from_reset(8'h9A);
        cur_req = "R6";
        send_word(8'h00, 1'b0);
        send_word(8'hFF, 1'b0);
        send_word(8'h55, 1'b0);
        send_word(8'hA3, 1'b0);

        cur_req = "R7";
        drive_bit(1'b1, 1'b0);
        drive_bit(1'b1, 1'b0);
        drive_bit(1'b1, 1'b0);
        send_word(8'h3C, 1'b1);
        send_word(8'h81, 1'b1);   // realign exactly at a word boundary

        cur_req = "R8";
        drive_bit(1'b1, 1'b0);
        drive_bit(1'b1, 1'b0);
        drive_bit(1'b1, 1'b0);
        drive_bit(1'b1, 1'b0);
        drive_bit(1'b0, 1'b0);
        rst = 1'b1;
        ce  = 1'b0;
        repeat (3) @(negedge clk);
        chk(word === 8'h00 && word_valid === 1'b0, "R8 cleared mid-stream", {word_valid, word}, 0);
        chk(expq.size() == 0, "R7 R8 pending words", expq.size(), 0);

        cur_req = "R5";
        send_word_from_reset(8'h5A);
        cur_req = "R6";
        send_word(8'hC3, 1'b0);
        ce = 1'b0;
        repeat (6) @(negedge clk);
        chk(expq.size() == 0, "R3 R6 words not presented", expq.size(), 0);
        mon_en = 1'b0;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule